// File: doc/BRIEF.md
# RV32IM Arithmetic Logic Unit

This unit carries out every integer arithmetic, logic, shift, compare, multiply, divide and remainder operation of the RV32I base set and the M extension. It is meant for a multi-cycle or pipelined core. The core has already muxed register and immediate values onto two 32-bit operands. It supplies the funct3 and funct7 fields, a flag that marks immediate-form instructions, a one-cycle start strobe and a flush strobe. The unit returns a registered 32-bit result and a done flag.

To keep area low, one barrel shifter serves both shift directions, with bit reversal around a single right shifter. One 33x33 signed multiplier serves all four multiply variants: multiplexers on its inputs set the signedness, and a multiplexer on its output picks the upper or lower half. Divide and remainder run through a serial restoring unit that works on magnitudes and fixes the signs at the end. That unit keeps done low for exactly 32 cycles. All other operations place their result in the register on the edge that takes the start strobe, and done stays high.

The core pulses flush at the end of each instruction. Flush clears the result and aborts a divide that is still running.

Top module: `rv_alu`

## Requirements
- R1: After reset the result is zero and done is high.
- R2: Register-form base operations are selected by funct3. The mapping is 000 add, or subtract when funct7 bit 5 is set; 001 shift left; 010 signed set-less-than; 011 unsigned set-less-than; 100 xor; 101 shift right; 110 or; 111 and. The result register is loaded on the edge that takes start, and done stays high.
- R3: With the immediate flag set, funct7 bit 5 never turns an add into a subtract, and funct7 bit 0 never selects a multiply or divide operation.
- R4: Shifts use the low 5 bits of the second operand as the amount. Funct3 101 with funct7 bit 5 set is an arithmetic right shift, in both register and immediate forms.
- R5: When funct7 bit 0 is set and the immediate flag is clear, funct3 000/001/010/011 give the low product, the high signed×signed product, the high signed×unsigned product and the high unsigned×unsigned product. These take one cycle, like the base operations.
- R6: Under the same funct7 encoding, funct3 100/101/110/111 give signed quotient, unsigned quotient, signed remainder and unsigned remainder, with the quotient truncated toward zero. Done goes low on the edge that takes start and stays low for exactly 32 cycles. The result is loaded on the edge at which done returns high.
- R7: Dividing by zero gives all ones as the quotient and the dividend as the remainder, in both signed and unsigned forms.
- R8: A signed division of 0x80000000 by 0xFFFFFFFF gives 0x80000000 as the quotient and zero as the remainder.
- R9: A start strobe that arrives while a divide is running is ignored. The divide finishes on time with its own result.
- R10: Flush clears the result to zero and forces done high on the next edge, aborting any running divide. A flush that comes in the same cycle as start wins, and that start is dropped.
- R11: While done is high and neither start nor flush is applied, the result holds its value, even when the operands and function fields change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin the selected operation (sampled only when idle) |
| flush | input | 1 | Clear result and abort any divide |
| is_imm | input | 1 | Instruction is the immediate form |
| funct3 | input | 3 | Operation field |
| funct7 | input | 7 | Operation modifier field |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand or immediate |
| result | output | 32 | Registered result |
| done | output | 1 | High unless a divide is in progress |

## Verification
Two events can fall on the same clock edge. Flush can collide with start, and a new start can arrive while a divide is still running. The bench drives flush and an add start together after a nonzero result is held, and expects zero with done high afterwards. It also pulses an add start in the middle of a division and expects the division's own quotient exactly 32 low cycles after the original start. A flush raised mid-divide must end the low period at once, leaving a zero result.

// File: rtl/alu_pkg.sv
package alu_pkg;
  parameter int unsigned XLEN = 32;
  localparam int unsigned SHW = $clog2(XLEN);
  localparam int unsigned CNTW = $clog2(XLEN);

  typedef enum logic [4:0] {
    OP_ADD, OP_SUB, OP_SLL, OP_SLT, OP_SLTU, OP_XOR, OP_SRL, OP_SRA,
    OP_OR, OP_AND, OP_MUL, OP_MULH, OP_MULHSU, OP_MULHU,
    OP_DIV, OP_DIVU, OP_REM, OP_REMU
  } alu_op_e;

  function automatic logic op_is_div(input alu_op_e op);
    return (op == OP_DIV) || (op == OP_DIVU) || (op == OP_REM) || (op == OP_REMU);
  endfunction

  function automatic logic [XLEN-1:0] bit_rev(input logic [XLEN-1:0] v);
    logic [XLEN-1:0] r;
    for (int i = 0; i < XLEN; i++) r[i] = v[XLEN-1-i];
    return r;
  endfunction

  function automatic logic [XLEN-1:0] magnitude(input logic [XLEN-1:0] v, input logic sgn);
    return (sgn && v[XLEN-1]) ? (~v + 1'b1) : v;
  endfunction

  // One restoring step: returns {partial remainder, quotient shift register}
  function automatic logic [2*XLEN-1:0] div_step(input logic [XLEN-1:0] prem,
                                                 input logic [XLEN-1:0] pquo,
                                                 input logic [XLEN-1:0] dvs);
    logic [XLEN+1:0] trial;
    trial = {1'b0, prem, pquo[XLEN-1]} - {2'b00, dvs};
    if (!trial[XLEN+1])
      return {trial[XLEN-1:0], pquo[XLEN-2:0], 1'b1};
    else
      return {prem[XLEN-2:0], pquo[XLEN-1], pquo[XLEN-2:0], 1'b0};
  endfunction
endpackage

// File: rtl/op_decode.sv
module op_decode
  import alu_pkg::*;
(
  input  logic       is_imm,
  input  logic [2:0] funct3,
  input  logic [6:0] funct7,
  output alu_op_e    op
);
  logic alt_bit;
  logic ext_bit;
  logic unused_f7;

  assign alt_bit   = funct7[5];
  assign ext_bit   = funct7[0] && !is_imm;
  assign unused_f7 = ^{funct7[6], funct7[4:1]};

  always_comb begin
    op = OP_ADD;
    if (ext_bit) begin
      unique case (funct3)
        3'b000: op = OP_MUL;
        3'b001: op = OP_MULH;
        3'b010: op = OP_MULHSU;
        3'b011: op = OP_MULHU;
        3'b100: op = OP_DIV;
        3'b101: op = OP_DIVU;
        3'b110: op = OP_REM;
        default: op = OP_REMU;
      endcase
    end else begin
      unique case (funct3)
        3'b000: op = (alt_bit && !is_imm) ? OP_SUB : OP_ADD;
        3'b001: op = OP_SLL;
        3'b010: op = OP_SLT;
        3'b011: op = OP_SLTU;
        3'b100: op = OP_XOR;
        3'b101: op = alt_bit ? OP_SRA : OP_SRL;
        3'b110: op = OP_OR;
        default: op = OP_AND;
      endcase
    end
  end
endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import alu_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [SHW-1:0]  amt,
  input  logic            left,
  input  logic            arith,
  output logic [XLEN-1:0] y
);
  logic [XLEN-1:0] src;
  logic            fill;
  logic [XLEN:0]   wide;
  logic [XLEN-1:0] right_out;
  logic            unused_top;

  assign src        = left ? bit_rev(a) : a;
  assign fill       = arith && !left && a[XLEN-1];
  assign wide       = $signed({fill, src}) >>> amt;
  assign right_out  = wide[XLEN-1:0];
  assign unused_top = wide[XLEN];
  assign y          = left ? bit_rev(right_out) : right_out;
endmodule

// File: rtl/mul_unit.sv
module mul_unit
  import alu_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            a_signed,
  input  logic            b_signed,
  input  logic            upper,
  output logic [XLEN-1:0] y
);
  logic signed [XLEN:0]     ax;
  logic signed [XLEN:0]     bx;
  logic signed [2*XLEN+1:0] prod;
  logic [1:0]               unused_hi;

  assign ax        = $signed({a_signed && a[XLEN-1], a});
  assign bx        = $signed({b_signed && b[XLEN-1], b});
  assign prod      = ax * bx;
  assign unused_hi = prod[2*XLEN+1:2*XLEN];
  assign y         = upper ? prod[2*XLEN-1:XLEN] : prod[XLEN-1:0];
endmodule

// File: rtl/div_serial.sv
module div_serial
  import alu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            go,
  input  logic            sgn,
  input  logic            want_rem,
  input  logic [XLEN-1:0] dividend,
  input  logic [XLEN-1:0] divisor,
  output logic            busy,
  output logic            fin,
  output logic [XLEN-1:0] res
);
  logic [XLEN-1:0] prem_q, pquo_q, dvs_q;
  logic [CNTW-1:0] cnt_q;
  logic            busy_q, neg_quo_q, neg_rem_q, rem_sel_q;
  logic [2*XLEN-1:0] stepped;
  logic [XLEN-1:0] prem_n, pquo_n;

  assign stepped = div_step(prem_q, pquo_q, dvs_q);
  assign prem_n  = stepped[2*XLEN-1:XLEN];
  assign pquo_n  = stepped[XLEN-1:0];
  assign busy    = busy_q;
  assign fin     = busy_q && (cnt_q == CNTW'(XLEN-1)) && !flush;

  always_comb begin
    if (rem_sel_q) res = neg_rem_q ? (~prem_n + 1'b1) : prem_n;
    else           res = neg_quo_q ? (~pquo_n + 1'b1) : pquo_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prem_q <= '0; pquo_q <= '0; dvs_q <= '0; cnt_q <= '0;
      busy_q <= 1'b0; neg_quo_q <= 1'b0; neg_rem_q <= 1'b0; rem_sel_q <= 1'b0;
    end else if (flush) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      prem_q <= prem_n;
      pquo_q <= pquo_n;
      cnt_q  <= cnt_q + 1'b1;
      if (cnt_q == CNTW'(XLEN-1)) busy_q <= 1'b0;
    end else if (go) begin
      prem_q    <= '0;
      pquo_q    <= magnitude(dividend, sgn);
      dvs_q     <= magnitude(divisor, sgn);
      cnt_q     <= '0;
      busy_q    <= 1'b1;
      rem_sel_q <= want_rem;
      neg_rem_q <= sgn && dividend[XLEN-1];
      neg_quo_q <= sgn && (dividend[XLEN-1] ^ divisor[XLEN-1]) && (divisor != '0);
    end
  end
endmodule

// File: rtl/rv_alu.sv
module rv_alu
  import alu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            flush,
  input  logic            is_imm,
  input  logic [2:0]      funct3,
  input  logic [6:0]      funct7,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic [XLEN-1:0] result,
  output logic            done
);
  alu_op_e         op;
  logic [XLEN-1:0] shift_y, mul_y, div_y, fast_y;
  logic            div_busy, div_fin;
  logic            accept, take_div;
  logic            sh_left, sh_arith;
  logic            m_as, m_bs, m_hi;

  op_decode u_dec (.is_imm(is_imm), .funct3(funct3), .funct7(funct7), .op(op));

  assign sh_left  = (op == OP_SLL);
  assign sh_arith = (op == OP_SRA);

  shift_unit u_shift (
    .a(opa), .amt(opb[SHW-1:0]), .left(sh_left), .arith(sh_arith), .y(shift_y)
  );

  assign m_as = (op == OP_MULH) || (op == OP_MULHSU);
  assign m_bs = (op == OP_MULH);
  assign m_hi = (op != OP_MUL);

  mul_unit u_mul (
    .a(opa), .b(opb), .a_signed(m_as), .b_signed(m_bs), .upper(m_hi), .y(mul_y)
  );

  assign accept   = start && !flush && !div_busy;
  assign take_div = accept && op_is_div(op);

  div_serial u_div (
    .clk(clk), .rst_n(rst_n), .flush(flush), .go(take_div),
    .sgn((op == OP_DIV) || (op == OP_REM)),
    .want_rem((op == OP_REM) || (op == OP_REMU)),
    .dividend(opa), .divisor(opb),
    .busy(div_busy), .fin(div_fin), .res(div_y)
  );

  always_comb begin
    unique case (op)
      OP_ADD:  fast_y = opa + opb;
      OP_SUB:  fast_y = opa - opb;
      OP_SLT:  fast_y = XLEN'($signed(opa) < $signed(opb));
      OP_SLTU: fast_y = XLEN'(opa < opb);
      OP_XOR:  fast_y = opa ^ opb;
      OP_OR:   fast_y = opa | opb;
      OP_AND:  fast_y = opa & opb;
      OP_SLL, OP_SRL, OP_SRA: fast_y = shift_y;
      OP_MUL, OP_MULH, OP_MULHSU, OP_MULHU: fast_y = mul_y;
      default: fast_y = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     result <= '0;
    else if (flush)                 result <= '0;
    else if (div_fin)               result <= div_y;
    else if (accept && !take_div)   result <= fast_y;
  end

  assign done = !div_busy;
endmodule

// File: rtl/alu_chk.sv
module alu_chk
  import alu_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            flush,
  input logic            done,
  input logic [XLEN-1:0] result,
  input logic            accept,
  input logic            take_div,
  input logic            div_fin
);
  logic [CNTW+1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    low_cnt <= '0;
    else if (done) low_cnt <= '0;
    else           low_cnt <= low_cnt + 1'b1;
  end

  // R6
  div_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_div |=> !done);
  // R6
  div_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && !$past(flush)) |-> (low_cnt == (CNTW+2)'(XLEN)));
  // R6
  div_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (low_cnt < (CNTW+2)'(XLEN)));
  // R2
  fast_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !take_div) |=> done);
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !div_fin && !flush) |=> !done);
  // R10
  flush_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (done && (result == '0)));
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start && !flush) |=> $stable(result));
endmodule

bind rv_alu alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .flush(flush), .done(done),
  .result(result), .accept(accept), .take_div(take_div), .div_fin(div_fin)
);

// File: tb/sim_rv_alu.sv
module sim_rv_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, flush = 1'b0, is_imm = 1'b0;
  logic [2:0]  funct3 = '0;
  logic [6:0]  funct7 = '0;
  logic [31:0] opa = '0, opb = '0;
  logic [31:0] result;
  logic        done;
  int          errors = 0, checks = 0, cyc = 0;

  rv_alu u0 (.clk(clk), .rst_n(rst_n), .start(start), .flush(flush), .is_imm(is_imm),
             .funct3(funct3), .funct7(funct7), .opa(opa), .opb(opb),
             .result(result), .done(done));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic imm, input logic [2:0] f3,
                                        input logic [6:0] f7,
                                        input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, ua, ub, p;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    ua = longint'({32'b0, a});  ub = longint'({32'b0, b});
    if (f7[0] && !imm) begin
      case (f3)
        3'd0: begin p = sa * sb; return p[31:0]; end
        3'd1: begin p = sa * sb; return p[63:32]; end
        3'd2: begin p = sa * ub; return p[63:32]; end
        3'd3: begin p = ua * ub; return p[63:32]; end
        3'd4: if (b == 0) return 32'hFFFFFFFF;
              else if (a == 32'h80000000 && b == 32'hFFFFFFFF) return a;
              else return 32'($signed(a) / $signed(b));
        3'd5: return (b == 0) ? 32'hFFFFFFFF : a / b;
        3'd6: if (b == 0) return a;
              else if (a == 32'h80000000 && b == 32'hFFFFFFFF) return 0;
              else return 32'($signed(a) % $signed(b));
        default: return (b == 0) ? a : a % b;
      endcase
    end
    case (f3)
      3'd0: return (f7[5] && !imm) ? a - b : a + b;
      3'd1: return a << b[4:0];
      3'd2: return {31'b0, sa < sb};
      3'd3: return {31'b0, a < b};
      3'd4: return a ^ b;
      3'd5: return f7[5] ? 32'($signed(a) >>> b[4:0]) : a >> b[4:0];
      3'd6: return a | b;
      default: return a & b;
    endcase
  endfunction

  // Issue one operation and check its result and the length of the low-done window.
  task automatic run_op(input string tag, input logic imm, input logic [2:0] f3,
                        input logic [6:0] f7, input logic [31:0] a, input logic [31:0] b);
    int lows = 0;
    int exp_lows;
    exp_lows = (f7[0] && !imm && f3[2]) ? 32 : 0;
    @(negedge clk);
    is_imm = imm; funct3 = f3; funct7 = f7; opa = a; opb = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && lows < 100) begin lows++; @(negedge clk); end
    check({tag, " result"}, result, model(imm, f3, f7, a, b));
    check({tag, " low cycles"}, 32'(lows), 32'(exp_lows));
  endtask

  task automatic t_reset;
    check("R1 reset result", result, 32'h0);
    check("R1 reset done", {31'b0, done}, 32'h1);
  endtask

  task automatic t_base;
    run_op("R2 add", 0, 3'd0, 7'h00, 32'h7FFFFFFF, 32'h1);
    run_op("R2 sub", 0, 3'd0, 7'h20, 32'h5, 32'h9);
    run_op("R2 slt", 0, 3'd2, 7'h00, 32'hFFFFFFFE, 32'h1);
    run_op("R2 sltu", 0, 3'd3, 7'h00, 32'hFFFFFFFE, 32'h1);
    run_op("R2 xor", 0, 3'd4, 7'h00, 32'hA5A5F00F, 32'h0FF0FF00);
    run_op("R2 or", 0, 3'd6, 7'h00, 32'h12340000, 32'h00005678);
    run_op("R2 and", 0, 3'd7, 7'h00, 32'hF0F0F0F0, 32'h3C3C3C3C);
  endtask

  task automatic t_imm;
    run_op("R3 imm add f7b5", 1, 3'd0, 7'h20, 32'h10, 32'h3);
    run_op("R3 imm add f7b0", 1, 3'd0, 7'h01, 32'h10, 32'h3);
    run_op("R3 imm f3=100 f7b0", 1, 3'd4, 7'h01, 32'hFF00FF00, 32'h0F0F0F0F);
  endtask

  task automatic t_shift;
    run_op("R4 sll", 0, 3'd1, 7'h00, 32'h80000001, 32'h00000024);
    run_op("R4 srl", 0, 3'd5, 7'h00, 32'h80000010, 32'h4);
    run_op("R4 sra", 0, 3'd5, 7'h20, 32'h80000010, 32'h4);
    run_op("R4 srai", 1, 3'd5, 7'h20, 32'hF0000000, 32'h1F);
    run_op("R4 slli 0", 1, 3'd1, 7'h00, 32'hDEADBEEF, 32'h0);
  endtask

  task automatic t_mul;
    run_op("R5 mul", 0, 3'd0, 7'h01, 32'hFFFFFFFD, 32'h00000007);
    run_op("R5 mulh", 0, 3'd1, 7'h01, 32'h80000000, 32'h80000000);
    run_op("R5 mulhsu", 0, 3'd2, 7'h01, 32'hFFFFFFFF, 32'hFFFFFFFF);
    run_op("R5 mulhu", 0, 3'd3, 7'h01, 32'hFFFFFFFF, 32'hFFFFFFFF);
  endtask

  task automatic t_div;
    run_op("R6 div", 0, 3'd4, 7'h01, 32'hFFFFFF9C, 32'h00000007);
    run_op("R6 divu", 0, 3'd5, 7'h01, 32'hFFFFFF9C, 32'h00000007);
    run_op("R6 rem", 0, 3'd6, 7'h01, 32'hFFFFFF9C, 32'h00000007);
    run_op("R6 remu", 0, 3'd7, 7'h01, 32'hFFFFFF9C, 32'h00000007);
    run_op("R6 rem neg divisor", 0, 3'd6, 7'h01, 32'd100, 32'hFFFFFFF9);
    run_op("R7 div by 0", 0, 3'd4, 7'h01, 32'hFFFFFF9C, 32'h0);
    run_op("R7 divu by 0", 0, 3'd5, 7'h01, 32'h1234, 32'h0);
    run_op("R7 rem by 0", 0, 3'd6, 7'h01, 32'hFFFFFF9C, 32'h0);
    run_op("R7 remu by 0", 0, 3'd7, 7'h01, 32'h1234, 32'h0);
    run_op("R8 overflow div", 0, 3'd4, 7'h01, 32'h80000000, 32'hFFFFFFFF);
    run_op("R8 overflow rem", 0, 3'd6, 7'h01, 32'h80000000, 32'hFFFFFFFF);
  endtask

  // A second start pulsed mid-divide must not disturb the divide.
  task automatic t_busy_start;
    int lows = 0;
    @(negedge clk);
    is_imm = 0; funct3 = 3'd5; funct7 = 7'h01; opa = 32'd1000; opb = 32'd7; start = 1;
    @(negedge clk); start = 0; lows = 1;
    repeat (5) begin @(negedge clk); lows++; end
    funct3 = 3'd0; funct7 = 7'h00; opa = 32'h55; opb = 32'h1; start = 1;
    @(negedge clk); start = 0; lows++;
    while (!done && lows < 100) begin @(negedge clk); lows++; end
    lows--;
    check("R9 busy start result", result, 32'd142);
    check("R9 busy start low cycles", 32'(lows), 32'd32);
  endtask

  task automatic t_flush;
    run_op("R10 setup add", 0, 3'd0, 7'h00, 32'h100, 32'h23);
    @(negedge clk);
    funct3 = 3'd0; funct7 = 7'h00; opa = 32'h9; opb = 32'h9; start = 1; flush = 1;
    @(negedge clk); start = 0; flush = 0;
    check("R10 flush beats start result", result, 32'h0);
    check("R10 flush beats start done", {31'b0, done}, 32'h1);
    @(negedge clk);
    check("R10 dropped start stays zero", result, 32'h0);
    run_op("R10 setup add2", 0, 3'd0, 7'h00, 32'h100, 32'h23);
    @(negedge clk);
    funct3 = 3'd4; funct7 = 7'h01; opa = 32'd500; opb = 32'd3; start = 1;
    @(negedge clk); start = 0;
    repeat (4) @(negedge clk);
    check("R10 divide running", {31'b0, done}, 32'h0);
    flush = 1;
    @(negedge clk); flush = 0;
    check("R10 abort done", {31'b0, done}, 32'h1);
    check("R10 abort result", result, 32'h0);
    repeat (40) @(negedge clk);
    check("R10 aborted stays zero", result, 32'h0);
  endtask

  task automatic t_hold;
    run_op("R11 setup", 0, 3'd7, 7'h00, 32'hCAFEF00D, 32'hFFFF0000);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      opa = 32'h1111 * (k + 3); opb = 32'h77; funct3 = 3'(k); funct7 = 7'h01;
      @(negedge clk);
      check("R11 hold", result, 32'hCAFE0000);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_base();
    t_imm();
    t_shift();
    t_mul();
    t_div();
    t_busy_start();
    t_flush();
    t_hold();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule